// File: doc/BRIEF.md
# Ordering-Stalled Access Prefetch Issuer

This block sits next to a processor's load and store buffers. Some buffered accesses are held back only by memory-ordering rules. The block turns each such access into a non-binding prefetch, so the line is already close when the ordering rule finally lets the access proceed. Loads ask for a shared copy of the line. Stores and atomic read-modify-writes ask for an exclusive copy, but only while the system runs invalidation-based coherence.

Accepted prefetches wait in a small FIFO queue. The queue head probes the cache, and a line that is already present is dropped on the spot. A miss is sent to memory and tracked until its reply comes back. The reply is then installed in the cache, and the line stays watched as a resident prefetched line. While a line is in flight, a demand reference to it is merged onto the outstanding request instead of sending a second one. Snooped remote traffic is checked against the tracked lines: a remote write cancels an in-flight install or invalidates a resident line, and a remote read takes away exclusive ownership.

Top module: `ordpf_issuer`

## Requirements
- R1: A candidate enters the queue only when `cand_valid`, `cand_order_wait` and `cand_cachable` are all 1 and `cand_fault` is 0. Any other candidate is dropped silently: it causes no probe, no memory request and no error.
- R2: Access kind encoding on `cand_kind`: 2'b00 is a read, 2'b01 is a write, 2'b10 is an atomic read-modify-write. A read produces a memory request with `mreq_excl`=0. A write or an atomic produces one with `mreq_excl`=1.
- R3: When `coh_inval`=0 (update-based coherence), write and atomic candidates are dropped. Read candidates are still accepted.
- R4: The queue head probes the cache (`probe_valid`, `probe_addr`). If `probe_hit`=1, the entry is discarded and no memory request is made.
- R5: On a probe miss, `mreq_valid` is raised in the same cycle, which is the cycle after the candidate was accepted into an empty queue. A reply on `mrsp_valid` whose address matches an in-flight line raises `fill_valid` in the same cycle, with `fill_excl` equal to the ownership of that request.
- R6: At most one memory request is outstanding per line. A queue head whose line is already tracked is discarded without a request.
- R7: A demand reference to a line that was in flight in an earlier cycle raises `dem_merged` in that cycle and sends no request. `dem_done` is raised in the cycle the reply arrives.
- R8: A remote write to an in-flight line cancels its install: the reply gives `fill_valid`=0, and if a demand was merged, `dem_retry`=1 instead of `dem_done`. A remote write to a resident prefetched line raises `snp_inval` in the same cycle and stops tracking that line.
- R9: A remote read to a resident line held exclusive raises `snp_downgrade` in the same cycle, and the line becomes shared, so a second remote read raises nothing.
- R10: The queue holds 4 entries. A candidate that arrives while 4 entries are queued is dropped without stalling anything.
- R11: Memory requests leave in the order their candidates were accepted.
- R12: After reset, the queue and tracker are empty and every output strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coh_inval | input | 1 | 1 = invalidation-based coherence, 0 = update-based |
| cand_valid | input | 1 | Candidate access present |
| cand_kind | input | 2 | 00 read, 01 write, 10 atomic |
| cand_addr | input | AW | Candidate line address |
| cand_order_wait | input | 1 | Access is waiting only on ordering rules |
| cand_cachable | input | 1 | Line is cachable |
| cand_fault | input | 1 | Address would fault |
| probe_valid | output | 1 | Cache lookup for the queue head |
| probe_addr | output | AW | Line being looked up |
| probe_hit | input | 1 | Looked-up line is present (same cycle) |
| mreq_valid | output | 1 | Prefetch request to memory |
| mreq_addr | output | AW | Requested line |
| mreq_excl | output | 1 | 1 = exclusive request, 0 = shared |
| mrsp_valid | input | 1 | Memory reply |
| mrsp_addr | input | AW | Line of the reply |
| fill_valid | output | 1 | Install the replied line in the cache |
| fill_addr | output | AW | Line to install |
| fill_excl | output | 1 | Install with exclusive ownership |
| dem_valid | input | 1 | Demand reference from the processor |
| dem_addr | input | AW | Demand line |
| dem_merged | output | 1 | Demand joined an in-flight prefetch |
| dem_done | output | 1 | Merged demand completes with this reply |
| dem_retry | output | 1 | Merged demand must refetch (install cancelled) |
| snp_valid | input | 1 | Remote coherence action observed |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | AW | Line of the remote action |
| snp_inval | output | 1 | Invalidate the resident prefetched line |
| snp_downgrade | output | 1 | Drop exclusive ownership of the line |

## Verification
On every cycle, the assertions check that a probe hit never leaves as a request and that a merged demand never emits one. They also check that a line is not requested twice in a row, that a reply cannot both complete and retry a demand, that one snoop never both invalidates and downgrades, and that the queue never exceeds its depth. Other behaviours need whole scenarios from the bench. These are the filtering of ineligible candidates, the mapping from access kind to ownership, suppression under update coherence, FIFO order, and the drop when the queue is full. The same holds for install cancellation by a remote write before the reply, and for the one-time nature of a downgrade.

// File: rtl/ordpf_issuer.sv
`timescale 1ns/1ps
module ordpf_issuer #(
  parameter int AW = 16,
  parameter int QD = 4,
  parameter int NT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coh_inval,
  input  logic          cand_valid,
  input  logic [1:0]    cand_kind,
  input  logic [AW-1:0] cand_addr,
  input  logic          cand_order_wait,
  input  logic          cand_cachable,
  input  logic          cand_fault,
  output logic          probe_valid,
  output logic [AW-1:0] probe_addr,
  input  logic          probe_hit,
  output logic          mreq_valid,
  output logic [AW-1:0] mreq_addr,
  output logic          mreq_excl,
  input  logic          mrsp_valid,
  input  logic [AW-1:0] mrsp_addr,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  output logic          fill_excl,
  input  logic          dem_valid,
  input  logic [AW-1:0] dem_addr,
  output logic          dem_merged,
  output logic          dem_done,
  output logic          dem_retry,
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_inval,
  output logic          snp_downgrade
);
  localparam int QW = (QD > 1) ? $clog2(QD) : 1;
  localparam int CW = $clog2(QD + 1);
  localparam int TW = (NT > 1) ? $clog2(NT) : 1;

  logic [AW-1:0] q_addr [QD];
  logic [QD-1:0] q_excl;
  logic [QW-1:0] q_rd, q_wr;
  logic [CW-1:0] q_cnt;

  logic [AW-1:0] t_addr [NT];
  logic [NT-1:0] t_val, t_res, t_excl, t_merg, t_kill;
  logic [NT-1:0] dm, sm, rm, ke, rdsnp;

  logic cand_excl, cand_ok, push, pop, issue, head_match, have_slot;
  logic [TW-1:0] slot;

  function automatic logic [QW-1:0] nxt(input logic [QW-1:0] p);
    return (p == QW'(QD - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cand_excl = (cand_kind != 2'b00);
  assign cand_ok   = cand_valid && cand_order_wait && cand_cachable && !cand_fault &&
                     (!cand_excl || coh_inval);
  assign push      = cand_ok && (q_cnt != CW'(QD));

  assign probe_valid = (q_cnt != '0);
  assign probe_addr  = q_addr[q_rd];

  always_comb begin
    head_match = 1'b0;
    for (int i = 0; i < NT; i++)
      if (t_val[i] && t_addr[i] == probe_addr) head_match = 1'b1;
  end

  always_comb begin
    slot = '0;
    have_slot = 1'b0;
    for (int i = NT - 1; i >= 0; i--)
      if (t_val[i] && t_res[i]) begin slot = TW'(i); have_slot = 1'b1; end
    for (int i = NT - 1; i >= 0; i--)
      if (!t_val[i]) begin slot = TW'(i); have_slot = 1'b1; end
  end

  assign issue = probe_valid && !probe_hit && !head_match && have_slot;
  assign pop   = probe_valid && (probe_hit || head_match || have_slot);

  assign mreq_valid = issue;
  assign mreq_addr  = probe_addr;
  assign mreq_excl  = q_excl[q_rd];

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[q_wr] <= cand_addr;
      q_excl[q_wr] <= cand_excl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_rd  <= '0;
      q_wr  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) q_wr <= nxt(q_wr);
      if (pop)  q_rd <= nxt(q_rd);
      case ({push, pop})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      dm[i]    = dem_valid  && t_val[i] && t_addr[i] == dem_addr;
      sm[i]    = snp_valid  && t_val[i] && t_addr[i] == snp_addr;
      rm[i]    = mrsp_valid && t_val[i] && !t_res[i] && t_addr[i] == mrsp_addr;
      ke[i]    = t_kill[i] || (sm[i] && snp_write);
      rdsnp[i] = sm[i] && !snp_write;
    end
  end

  assign dem_merged    = |(dm & ~t_res);
  assign fill_valid    = |(rm & ~ke);
  assign fill_addr     = mrsp_addr;
  assign fill_excl     = |(rm & ~ke & t_excl & ~rdsnp);
  assign dem_done      = |(rm & ~ke & (t_merg | dm));
  assign dem_retry     = |(rm & ke & (t_merg | dm));
  assign snp_inval     = snp_write && |(sm & t_res);
  assign snp_downgrade = !snp_write && |(sm & t_res & t_excl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_val  <= '0;
      t_res  <= '0;
      t_excl <= '0;
      t_merg <= '0;
      t_kill <= '0;
      for (int i = 0; i < NT; i++) t_addr[i] <= '0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (rm[i]) begin
          if (ke[i] || t_merg[i] || dm[i]) begin
            t_val[i] <= 1'b0;
          end else begin
            t_res[i]  <= 1'b1;
            t_excl[i] <= t_excl[i] && !rdsnp[i];
          end
        end else if (t_res[i]) begin
          if (dm[i] || (sm[i] && snp_write)) t_val[i] <= 1'b0;
          else if (rdsnp[i])                 t_excl[i] <= 1'b0;
        end else if (t_val[i]) begin
          if (dm[i])                t_merg[i] <= 1'b1;
          if (sm[i] && snp_write)   t_kill[i] <= 1'b1;
          if (rdsnp[i])             t_excl[i] <= 1'b0;
        end
        if (issue && slot == TW'(i)) begin
          t_val[i]  <= 1'b1;
          t_res[i]  <= 1'b0;
          t_addr[i] <= probe_addr;
          t_excl[i] <= q_excl[q_rd];
          t_merg[i] <= 1'b0;
          t_kill[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ordpf_issuer_chk.sv
`timescale 1ns/1ps
module ordpf_issuer_chk #(
  parameter int AW = 16,
  parameter int QD = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          probe_valid,
  input logic          probe_hit,
  input logic          mreq_valid,
  input logic [AW-1:0] mreq_addr,
  input logic          dem_merged,
  input logic [AW-1:0] dem_addr,
  input logic          dem_done,
  input logic          dem_retry,
  input logic          snp_inval,
  input logic          snp_downgrade,
  input logic [CW-1:0] q_cnt
);
  AST_HIT_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_hit) |-> !mreq_valid); // R4
  AST_REQ_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (probe_valid && !probe_hit)); // R5
  AST_NO_REPEAT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |=> !(mreq_valid && mreq_addr == $past(mreq_addr))); // R6
  AST_MERGE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dem_merged |-> !(mreq_valid && mreq_addr == dem_addr)); // R7
  AST_DONE_OR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    !(dem_done && dem_retry)); // R8
  AST_ONE_SNOOP_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_inval && snp_downgrade)); // R9
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(QD)); // R10
endmodule

bind ordpf_issuer ordpf_issuer_chk #(.AW(AW), .QD(QD), .CW($clog2(QD + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_hit(probe_hit),
  .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .dem_merged(dem_merged),
  .dem_addr(dem_addr), .dem_done(dem_done), .dem_retry(dem_retry),
  .snp_inval(snp_inval), .snp_downgrade(snp_downgrade), .q_cnt(q_cnt)
);

// File: tb/ordpf_issuer_tb.sv
`timescale 1ns/1ps
module ordpf_issuer_tb;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0, coh_inval = 1;
  logic cand_valid = 0, cand_order_wait = 0, cand_cachable = 0, cand_fault = 0;
  logic [1:0] cand_kind = 0;
  logic [AW-1:0] cand_addr = 0, probe_addr, mreq_addr, mrsp_addr = 0, fill_addr, dem_addr = 0, snp_addr = 0;
  logic probe_valid, probe_hit, mreq_valid, mreq_excl, mrsp_valid = 0, fill_valid, fill_excl;
  logic dem_valid = 0, dem_merged, dem_done, dem_retry, snp_valid = 0, snp_write = 0, snp_inval, snp_downgrade;

  bit cache [256];
  assign probe_hit = cache[probe_addr];

  ordpf_issuer #(.AW(AW)) u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_log = 0;
  bit finished = 0;
  logic [AW-1:0] log_addr [2048];
  bit log_excl [2048];
  bit s_probe, s_mreq, s_mexcl, s_fill, s_fexcl, s_merged, s_done, s_retry, s_inval, s_dgrade;
  logic [AW-1:0] s_maddr;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply();
    bit uf, ui;
    logic [AW-1:0] fa, ia;
    @(negedge clk);
    s_probe = probe_valid; s_mreq = mreq_valid; s_maddr = mreq_addr; s_mexcl = mreq_excl;
    s_fill = fill_valid; s_fexcl = fill_excl; s_merged = dem_merged; s_done = dem_done;
    s_retry = dem_retry; s_inval = snp_inval; s_dgrade = snp_downgrade;
    if (mreq_valid && n_log < 2048) begin
      log_addr[n_log] = mreq_addr; log_excl[n_log] = mreq_excl; n_log++;
    end
    uf = fill_valid; fa = fill_addr; ui = snp_inval; ia = snp_addr;
    @(posedge clk); #1;
    if (uf) cache[fa] = 1;
    if (ui) cache[ia] = 0;
    cand_valid = 0; mrsp_valid = 0; dem_valid = 0; snp_valid = 0;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [1:0] k,
                      input bit w = 1, input bit c = 1, input bit f = 0);
    cand_valid = 1; cand_addr = a; cand_kind = k;
    cand_order_wait = w; cand_cachable = c; cand_fault = f;
    apply();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) apply();
  endtask

  task automatic rsp(input logic [AW-1:0] a);
    mrsp_valid = 1; mrsp_addr = a; apply();
  endtask

  task automatic dem(input logic [AW-1:0] a);
    dem_valid = 1; dem_addr = a; apply();
  endtask

  task automatic snp(input logic [AW-1:0] a, input bit w);
    snp_valid = 1; snp_addr = a; snp_write = w; apply();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  bit pend [256];
  bit pexcl [256];
  bit pmerg [256];
  logic [AW-1:0] plist [8];
  int pn = 0;

  initial begin
    int base;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    apply();
    chk("R12 probe idle", s_probe, 0);
    chk("R12 outputs idle", s_mreq | s_fill | s_merged | s_done | s_retry | s_inval | s_dgrade, 0);

    // R2 / R11 / R5: three kinds in order
    base = n_log;
    push(8'h10, 2'b00); push(8'h11, 2'b01); push(8'h12, 2'b10); idle(2);
    chk("R5 three requests", n_log - base, 3);
    chk("R11 order 0", log_addr[base], 8'h10);
    chk("R11 order 1", log_addr[base+1], 8'h11);
    chk("R11 order 2", log_addr[base+2], 8'h12);
    chk("R2 read shared", log_excl[base], 0);
    chk("R2 write excl", log_excl[base+1], 1);
    chk("R2 atomic excl", log_excl[base+2], 1);
    rsp(8'h10);
    chk("R5 fill read", s_fill, 1); chk("R5 fill read own", s_fexcl, 0);
    rsp(8'h11);
    chk("R5 fill write", s_fill, 1); chk("R5 fill write own", s_fexcl, 1);

    // R4: cached line
    cache[8'h40] = 1;
    base = n_log;
    push(8'h40, 2'b00); idle(2);
    chk("R4 hit dropped", n_log - base, 0);

    // R1: ineligible candidates
    base = n_log;
    push(8'h50, 2'b00, 0, 1, 0);
    apply(); chk("R1 no probe when not ordering-held", s_probe, 0);
    push(8'h51, 2'b01, 1, 0, 0);
    apply(); chk("R1 no probe when uncachable", s_probe, 0);
    push(8'h52, 2'b00, 1, 1, 1);
    apply(); chk("R1 no probe when faulting", s_probe, 0);
    chk("R1 no requests", n_log - base, 0);

    // R3: update coherence
    coh_inval = 0;
    base = n_log;
    push(8'h60, 2'b01); push(8'h62, 2'b10); push(8'h61, 2'b00); idle(2);
    chk("R3 only read issued", n_log - base, 1);
    chk("R3 read addr", log_addr[base], 8'h61);
    chk("R3 read shared", log_excl[base], 0);
    coh_inval = 1;

    // R6: duplicate of in-flight line
    base = n_log;
    push(8'h12, 2'b00); idle(2);
    chk("R6 duplicate suppressed", n_log - base, 0);

    // R7: merge
    base = n_log;
    dem(8'h12);
    chk("R7 merged", s_merged, 1);
    chk("R7 no request", s_mreq, 0);
    rsp(8'h12);
    chk("R7 done on reply", s_done, 1);
    chk("R7 fill on reply", s_fill, 1);
    chk("R7 no extra request", n_log - base, 0);

    // R8: remote write cancels in-flight install
    snp(8'h61, 1);
    chk("R8 no inval for in-flight", s_inval, 0);
    rsp(8'h61);
    chk("R8 cancelled fill", s_fill, 0);
    push(8'h70, 2'b00); idle(1);
    dem(8'h70); chk("R7 merged second", s_merged, 1);
    snp(8'h70, 1);
    rsp(8'h70);
    chk("R8 retry", s_retry, 1); chk("R8 no done", s_done, 0); chk("R8 no fill", s_fill, 0);

    // R9 / R8 on resident exclusive line 0x11
    snp(8'h11, 0);
    chk("R9 downgrade", s_dgrade, 1);
    snp(8'h11, 0);
    chk("R9 second read silent", s_dgrade, 0);
    snp(8'h11, 1);
    chk("R8 resident inval", s_inval, 1);
    snp(8'h11, 1);
    chk("R8 untracked after inval", s_inval, 0);

    // R10: full queue drops
    base = n_log;
    for (int i = 0; i < 4; i++) push(AW'(8'h80 + i), 2'b00);
    idle(2);
    chk("R10 tracker filled", n_log - base, 4);
    for (int i = 0; i < 5; i++) push(AW'(8'h84 + i), 2'b00);
    idle(3);
    chk("R10 head stalls", n_log - base, 4);
    for (int i = 0; i < 4; i++) rsp(AW'(8'h80 + i));
    idle(6);
    chk("R10 fifth dropped", n_log - base, 8);
    for (int i = 0; i < 4; i++) chk("R11 queued order", log_addr[base+4+i], 8'h84 + i);
    for (int i = 0; i < 4; i++) rsp(AW'(8'h84 + i));
    idle(2);

    // random phase: R4 R5 R6 R7
    for (int c = 0; c < 600; c++) begin
      logic [AW-1:0] ra, da, ea;
      bit dr, dd;
      int idx;
      cand_valid = ($urandom % 2) == 0;
      cand_addr = AW'(8'hA0 + ($urandom % 16));
      cand_kind = 2'($urandom % 3);
      cand_order_wait = 1; cand_cachable = 1; cand_fault = 0;
      dr = 0; dd = 0; idx = 0; ra = 0; da = 0;
      if (pn > 0 && ($urandom % 3) == 0) begin
        idx = int'($urandom % pn); ra = plist[idx]; dr = 1;
        mrsp_valid = 1; mrsp_addr = ra;
      end
      if (($urandom % 4) == 0) begin
        da = AW'(8'hA0 + ($urandom % 16));
        if (!(dr && da == ra)) begin dd = 1; dem_valid = 1; dem_addr = da; end
      end
      apply();
      if (dd) begin
        chk("R7 random merge", s_merged, pend[da]);
        if (s_merged) pmerg[da] = 1;
      end
      if (dr) begin
        chk("R5 random fill", s_fill, 1);
        chk("R5 random ownership", s_fexcl, pexcl[ra]);
        chk("R7 random done", s_done, pmerg[ra]);
        pend[ra] = 0;
        plist[idx] = plist[pn-1]; pn--;
      end
      if (s_mreq) begin
        chk("R6 random unique", pend[s_maddr], 0);
        chk("R4 random not cached", cache[s_maddr], 0);
        if (pn < 8) begin
          pend[s_maddr] = 1; pexcl[s_maddr] = s_mexcl; pmerg[s_maddr] = 0;
          plist[pn] = s_maddr; pn++;
        end
      end
      if (($urandom % 5) == 0) begin
        ea = AW'(8'hA0 + ($urandom % 16));
        if (!pend[ea]) cache[ea] = 0;
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule